// File: doc/BRIEF.md
# Packet Descriptor Ring Writer

This block turns one packet send request into a run of 128-bit descriptors and writes them into a circular descriptor memory. A request arrives as a stream of beats. The first beat carries the header segment and the request options. Each later beat carries one payload segment. Each beat gives a 48-bit address and a length in dwords. The block writes one descriptor per accepted beat, at the working tail index. It marks the first and final descriptors, stamps every descriptor with a 2-bit generation that advances each time the index wraps, and records in each descriptor the dword offset into the send buffer.

When the final beat is accepted, the block publishes the new tail index and the running 16-bit count of descriptors added, then returns a one-cycle response carrying the start index and next index. The engine that consumes the ring reports its own 16-bit running count of removed descriptors. The block uses that count to work out free space on the header beat. If the packet does not fit, the block refuses it: the beats are drained through the final one, nothing is written, and the response is flagged as a reject.

Top module: `desc_ring_writer`

## Requirements
- R1: Descriptor word 0 sits in data bits [63:0]. In word 0, bits [10:0] hold the send-buffer dword offset, bit 11 marks LAST, bit 12 marks FIRST, bit 13 requests head writeback, bit 14 selects the large buffer and bit 15 requests an interrupt.
- R2: Word 0 bits [26:16] hold the segment dword count, bits [29:27] are zero and bits [63:32] hold address bits [31:2] with bits [33:32] zero. Word 1 (data bits [127:64]) holds address bits [47:32] in its low 16 bits and zero above them.
- R3: A descriptor is written in the same cycle its beat is accepted. The header goes to the published tail, and each later descriptor goes to the next index, wrapping from DEPTH-1 to 0.
- R4: The generation field starts at 0 after reset. It increments (mod 4) for every descriptor written after the index wraps from DEPTH-1 to 0.
- R5: The header descriptor has FIRST set, offset 0 and the header length as its count. Payload descriptors have FIRST clear.
- R6: The offset of a payload descriptor is the header length plus the lengths of the earlier payload segments, taken mod 2048.
- R7: When the header beat requests the large buffer, every descriptor of that packet has bit 14 set. Otherwise no descriptor of that packet has it set.
- R8: Only the final descriptor of a packet has LAST set. Head writeback and interrupt appear only on the final descriptor, and only when the header beat requested them.
- R9: One cycle after the final beat of an accepted packet, tail_out moves to the index after the last descriptor and added_out grows by the packet's descriptor count (mod 2^16). At no other time do they change.
- R10: Free space is DEPTH-1-(added_out-rm_cnt) mod 2^16. A request whose declared descriptor count exceeds it is refused: every beat through the final one is accepted with no write, and tail_out and added_out stay unchanged.
- R11: One cycle after the final beat, done_valid is high for exactly one cycle, with done_start/done_next giving the first index and the index after the last. On a reject, done_reject is high and both indices equal the tail. req_ready is low only in the cycle done_valid is high.
- R12: After reset, tail_out, added_out and the generation are 0, done_valid is low and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request beat valid |
| req_ready | output | 1 | Block accepts a beat |
| req_addr | input | 48 | Segment address |
| req_dw | input | 11 | Segment length in dwords |
| req_last | input | 1 | Final beat of the request |
| req_ndesc | input | $clog2(MAX_SEG+2) | Descriptor count of the request (header beat) |
| req_large | input | 1 | Large-buffer option (header beat) |
| req_hwb | input | 1 | Head-writeback option (header beat) |
| req_intr | input | 1 | Interrupt option (header beat) |
| rm_cnt | input | 16 | Running count of removed descriptors |
| dsc_we | output | 1 | Descriptor write enable |
| dsc_idx | output | $clog2(DEPTH) | Descriptor write index |
| dsc_data | output | 128 | Descriptor write data |
| tail_out | output | $clog2(DEPTH) | Published tail index |
| added_out | output | 16 | Running count of added descriptors |
| done_valid | output | 1 | Response pulse |
| done_reject | output | 1 | Request was refused |
| done_start | output | $clog2(DEPTH) | First index of the packet |
| done_next | output | $clog2(DEPTH) | Index after the packet |

## Verification
A corrupted working index shows up at the very next write, because the descriptor lands away from the published tail or away from the slot after its predecessor. A slipped generation counter shows up in the first descriptor written after a wrap. A wrong added count or removed-count difference appears in added_out one cycle after the packet. It then causes the next request near a full ring to be wrongly accepted or refused. The bench drives an exact-fit request, a request one over the limit, segment gaps, ring wraps and offset wraps, and compares every output against a behavioural model on every cycle.

// File: rtl/desc_ring_writer.sv
module desc_ring_writer #(
  parameter int DEPTH   = 256,
  parameter int MAX_SEG = 15,
  localparam int IW = $clog2(DEPTH),
  localparam int NW = $clog2(MAX_SEG + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [47:0]   req_addr,
  input  logic [10:0]   req_dw,
  input  logic          req_last,
  input  logic [NW-1:0] req_ndesc,
  input  logic          req_large,
  input  logic          req_hwb,
  input  logic          req_intr,
  input  logic [15:0]   rm_cnt,
  output logic          dsc_we,
  output logic [IW-1:0] dsc_idx,
  output logic [127:0]  dsc_data,
  output logic [IW-1:0] tail_out,
  output logic [15:0]   added_out,
  output logic          done_valid,
  output logic          done_reject,
  output logic [IW-1:0] done_start,
  output logic [IW-1:0] done_next
);

  logic [IW-1:0] wptr, tail_q, start_q, ds_q, dn_q, nxt;
  logic [1:0]    gen_q;
  logic [15:0]   added_q, inflight, free_cnt;
  logic [10:0]   offs_q, off_x;
  logic [NW-1:0] nd_q, nd_x;
  logic          busy_q, drop_q, large_q, hwb_q, intr_q;
  logic          dv_q, rej_q;
  logic          take, hdr, refuse, skip, wrap, large_x, hwb_x, intr_x;
  logic [1:0]    addr_lo_unused;

  assign addr_lo_unused = req_addr[1:0];

  assign req_ready = ~dv_q;
  assign take      = req_valid & req_ready;
  assign hdr       = ~busy_q;

  assign inflight = added_q - rm_cnt;
  assign free_cnt = 16'(DEPTH - 1) - inflight;
  assign refuse   = hdr & (16'(req_ndesc) > free_cnt);
  assign skip     = hdr ? refuse : drop_q;

  assign wrap = (wptr == IW'(DEPTH - 1));
  assign nxt  = wrap ? '0 : wptr + 1'b1;

  assign large_x = hdr ? req_large : large_q;
  assign hwb_x   = hdr ? req_hwb   : hwb_q;
  assign intr_x  = hdr ? req_intr  : intr_q;
  assign off_x   = hdr ? 11'd0     : offs_q;
  assign nd_x    = hdr ? req_ndesc : nd_q;

  assign dsc_we   = take & ~skip;
  assign dsc_idx  = wptr;
  assign dsc_data = {48'd0, req_addr[47:32],
                     req_addr[31:2], 2'b00, gen_q, 3'b000, req_dw,
                     req_last & intr_x, large_x, req_last & hwb_x,
                     hdr, req_last, off_x};

  assign tail_out    = tail_q;
  assign added_out   = added_q;
  assign done_valid  = dv_q;
  assign done_reject = rej_q;
  assign done_start  = ds_q;
  assign done_next   = dn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; tail_q <= '0; start_q <= '0; ds_q <= '0; dn_q <= '0;
      gen_q <= '0; added_q <= '0; offs_q <= '0; nd_q <= '0;
      busy_q <= 1'b0; drop_q <= 1'b0; large_q <= 1'b0; hwb_q <= 1'b0;
      intr_q <= 1'b0; dv_q <= 1'b0; rej_q <= 1'b0;
    end else begin
      dv_q <= take & req_last;
      if (take) begin
        if (hdr) begin
          start_q <= wptr;
          nd_q    <= req_ndesc;
          drop_q  <= refuse;
          large_q <= req_large;
          hwb_q   <= req_hwb;
          intr_q  <= req_intr;
          busy_q  <= ~req_last;
        end else if (req_last) begin
          busy_q <= 1'b0;
        end
        if (dsc_we) begin
          wptr   <= nxt;
          offs_q <= off_x + req_dw;
          if (wrap) gen_q <= gen_q + 2'd1;
        end
        if (req_last) begin
          rej_q <= skip;
          ds_q  <= hdr ? wptr : start_q;
          dn_q  <= dsc_we ? nxt : wptr;
          if (!skip) begin
            tail_q  <= nxt;
            added_q <= added_q + 16'(nd_x);
          end
        end
      end
    end
  end

endmodule

// File: rtl/desc_ring_writer_chk.sv
module desc_ring_writer_chk #(
  parameter int DEPTH = 256,
  localparam int IW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          dsc_we,
  input logic [IW-1:0] dsc_idx,
  input logic [15:0]   w0_flags,
  input logic [1:0]    w0_gen,
  input logic [IW-1:0] tail_out,
  input logic [15:0]   added_out,
  input logic          done_valid,
  input logic          done_reject,
  input logic [IW-1:0] done_start,
  input logic [IW-1:0] done_next
);

  // R5
  first_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_we && w0_flags[12] |-> w0_flags[10:0] == 11'd0);

  // R3
  hdr_at_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_we && w0_flags[12] |-> dsc_idx == tail_out);

  // R8
  opt_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_we && (w0_flags[13] || w0_flags[15]) |-> w0_flags[11]);

  // R4
  gen_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_we && $past(dsc_we) && dsc_idx == '0 |-> w0_gen == $past(w0_gen) + 2'd1);

  // R7
  large_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_we && !w0_flags[12] && $past(dsc_we) |-> w0_flags[14] == $past(w0_flags[14]));

  // R9
  tail_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail_out != $past(tail_out) |-> done_valid && !done_reject && tail_out == done_next);

  // R10
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_reject |-> done_start == done_next && $stable(added_out));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  // R11
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !req_ready);

endmodule

bind desc_ring_writer desc_ring_writer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .dsc_we(dsc_we),
  .dsc_idx(dsc_idx), .w0_flags(dsc_data[15:0]), .w0_gen(dsc_data[31:30]),
  .tail_out(tail_out), .added_out(added_out), .done_valid(done_valid),
  .done_reject(done_reject), .done_start(done_start), .done_next(done_next)
);

// File: tb/test_desc_ring_writer.sv
`timescale 1ns/1ps
module test_desc_ring_writer;
  localparam int DEPTH = 16, MAX_SEG = 7, IW = 4, NW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_last = 1'b0, req_large = 1'b0, req_hwb = 1'b0, req_intr = 1'b0;
  logic [47:0] req_addr = '0;
  logic [10:0] req_dw = '0;
  logic [NW-1:0] req_ndesc = '0;
  logic [15:0] rm_cnt = '0;
  logic req_ready, dsc_we, done_valid, done_reject;
  logic [IW-1:0] dsc_idx, tail_out, done_start, done_next;
  logic [127:0] dsc_data;
  logic [15:0] added_out;

  int total = 0, bad = 0;
  int lens[8];

  desc_ring_writer #(.DEPTH(DEPTH), .MAX_SEG(MAX_SEG)) i_desc_ring_writer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_dw(req_dw), .req_last(req_last), .req_ndesc(req_ndesc),
    .req_large(req_large), .req_hwb(req_hwb), .req_intr(req_intr), .rm_cnt(rm_cnt),
    .dsc_we(dsc_we), .dsc_idx(dsc_idx), .dsc_data(dsc_data), .tail_out(tail_out),
    .added_out(added_out), .done_valid(done_valid), .done_reject(done_reject),
    .done_start(done_start), .done_next(done_next));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference state
  int m_tail, m_pub, m_gen, m_added, m_offs, m_start, m_nd, m_ds, m_dn;
  bit m_busy, m_drop, m_large, m_hwb, m_intr, m_dv, m_rej;
  bit e_take, e_hdr, e_skip, e_we, e_ref;

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      int freec, off, cnt;
      bit fl, lg, hw, it;
      e_hdr  = !m_busy;
      e_take = req_valid && !m_dv;
      freec  = (DEPTH - 1 - ((m_added - int'(rm_cnt)) & 16'hffff)) & 16'hffff;
      e_ref  = e_hdr && (int'(req_ndesc) > freec);
      e_skip = e_hdr ? e_ref : m_drop;
      e_we   = e_take && !e_skip;
      chk(req_ready == !m_dv, "R11 ready", 64'(req_ready), 64'(!m_dv));
      chk(dsc_we == e_we, "R10 write enable", 64'(dsc_we), 64'(e_we));
      chk(tail_out == m_pub[IW-1:0], "R9 tail_out", 64'(tail_out), 64'(m_pub));
      chk(added_out == m_added[15:0], "R9 added_out", 64'(added_out), 64'(m_added));
      chk(done_valid == m_dv, "R11 done_valid", 64'(done_valid), 64'(m_dv));
      if (m_dv) begin
        chk(done_reject == m_rej, "R10 done_reject", 64'(done_reject), 64'(m_rej));
        chk(done_start == m_ds[IW-1:0], "R11 done_start", 64'(done_start), 64'(m_ds));
        chk(done_next == m_dn[IW-1:0], "R11 done_next", 64'(done_next), 64'(m_dn));
      end
      if (e_we && dsc_we) begin
        off = e_hdr ? 0 : m_offs;
        cnt = int'(req_dw);
        lg  = e_hdr ? req_large : m_large;
        hw  = (e_hdr ? req_hwb : m_hwb) && req_last;
        it  = (e_hdr ? req_intr : m_intr) && req_last;
        fl  = e_hdr;
        chk(dsc_idx == m_tail[IW-1:0], "R3 index", 64'(dsc_idx), 64'(m_tail));
        chk(dsc_data[10:0] == off[10:0], "R6 offset", 64'(dsc_data[10:0]), 64'(off));
        chk(dsc_data[11] == req_last, "R8 last flag", 64'(dsc_data[11]), 64'(req_last));
        chk(dsc_data[12] == fl, "R5 first flag", 64'(dsc_data[12]), 64'(fl));
        chk(dsc_data[13] == hw, "R8 head writeback", 64'(dsc_data[13]), 64'(hw));
        chk(dsc_data[14] == lg, "R7 large flag", 64'(dsc_data[14]), 64'(lg));
        chk(dsc_data[15] == it, "R1 interrupt flag", 64'(dsc_data[15]), 64'(it));
        chk(dsc_data[26:16] == cnt[10:0], "R2 count", 64'(dsc_data[26:16]), 64'(cnt));
        chk(dsc_data[29:27] == 3'd0, "R2 reserved", 64'(dsc_data[29:27]), 64'd0);
        chk(dsc_data[31:30] == m_gen[1:0], "R4 generation", 64'(dsc_data[31:30]), 64'(m_gen));
        chk(dsc_data[63:32] == {req_addr[31:2], 2'b00}, "R2 address low",
            dsc_data[63:32], 64'({req_addr[31:2], 2'b00}));
        chk(dsc_data[127:64] == {48'd0, req_addr[47:32]}, "R2 address high",
            dsc_data[127:64], 64'(req_addr[47:32]));
      end
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tail = 0; m_pub = 0; m_gen = 0; m_added = 0; m_offs = 0; m_start = 0; m_nd = 0;
      m_ds = 0; m_dn = 0; m_busy = 0; m_drop = 0; m_large = 0; m_hwb = 0; m_intr = 0;
      m_dv = 0; m_rej = 0;
    end else begin
      int nd;
      bit ndv;
      nd  = e_hdr ? int'(req_ndesc) : m_nd;
      ndv = e_take && req_last;
      if (e_take) begin
        if (e_hdr) begin
          m_start = m_tail; m_nd = int'(req_ndesc); m_drop = e_ref;
          m_large = req_large; m_hwb = req_hwb; m_intr = req_intr; m_busy = !req_last;
        end else if (req_last) m_busy = 0;
        if (e_we) begin
          m_offs = ((e_hdr ? 0 : m_offs) + int'(req_dw)) & 2047;
          if (m_tail == DEPTH - 1) m_gen = (m_gen + 1) & 3;
          m_tail = (m_tail + 1) % DEPTH;
        end
        if (req_last) begin
          m_rej = e_skip; m_ds = m_start; m_dn = m_tail;
          if (!e_skip) begin
            m_pub = m_tail;
            m_added = (m_added + nd) & 16'hffff;
          end
        end
      end
      m_dv = ndv;
    end
  end

  task automatic send(input int nd, input int hdrlen, input bit lg, input bit hw,
                      input bit it, input bit gap, input logic [47:0] base);
    for (int i = 0; i < nd; i++) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = base + 48'(i * 68 + 3);
      req_dw    = (i == 0) ? 11'(hdrlen) : 11'(lens[i]);
      req_last  = (i == nd - 1);
      req_ndesc = NW'(nd);
      req_large = lg; req_hwb = hw; req_intr = it;
      while (!req_ready) @(negedge clk);
      if (gap && i != nd - 1) begin
        @(negedge clk);
        req_valid = 1'b0;
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    req_last  = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    rm_cnt = added_out;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R11 watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R12 reset state
    chk(tail_out == '0, "R12 tail after reset", 64'(tail_out), 64'd0);
    chk(added_out == 16'd0, "R12 added after reset", 64'(added_out), 64'd0);
    chk(!done_valid, "R12 done after reset", 64'(done_valid), 64'd0);
    chk(!dsc_we, "R12 no write after reset", 64'(dsc_we), 64'd0);

    // single descriptor packet with both final options (R1, R8)
    send(1, 5, 1'b0, 1'b1, 1'b1, 1'b0, 48'h1234_5678_9ABF);
    // header plus three payloads, large buffer, gaps (R5, R6, R7)
    lens[1] = 10; lens[2] = 20; lens[3] = 30;
    send(4, 8, 1'b1, 1'b0, 1'b1, 1'b1, 48'hABCD_0000_1000);
    drain();
    // wrap the ring twice to move the generation (R3, R4)
    for (int p = 0; p < 9; p++) begin
      lens[1] = p + 1; lens[2] = 2; lens[3] = 7;
      send(4, 3 + p, p[0], p[1], 1'b0, p[2], 48'h0000_FFFF_FFF0 + 48'(p * 4096));
      drain();
    end
    // fill toward full: free 15 -> 8 -> 1 (R10)
    for (int i = 1; i < 8; i++) lens[i] = i;
    send(7, 4, 1'b0, 1'b0, 1'b0, 1'b0, 48'h0000_2000_0000);
    send(7, 4, 1'b0, 1'b0, 1'b0, 1'b0, 48'h0000_3000_0000);
    // one over the limit: refused, beats drained (R10)
    send(2, 4, 1'b1, 1'b1, 1'b1, 1'b0, 48'h0000_4000_0000);
    // exact fit accepted (R10)
    send(1, 4, 1'b0, 1'b1, 1'b0, 1'b0, 48'h0000_5000_0000);
    // ring now full: refused (R10)
    send(1, 4, 1'b0, 1'b0, 1'b0, 1'b0, 48'h0000_6000_0000);
    @(negedge clk); #1;
    chk(added_out == 16'(m_added), "R10 added after refusals", 64'(added_out), 64'(m_added));
    drain();
    // offset wraps past 2047 (R6)
    lens[1] = 100; lens[2] = 5;
    send(3, 2000, 1'b1, 1'b0, 1'b0, 1'b0, 48'h7FFF_FFFF_FFFF);
    drain();
    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule